// File: doc/BRIEF.md
# Task Register Load Checker

This block decides whether a request to load the task register may go ahead. A request carries a 16-bit segment selector, the type nibble and limit of the system descriptor that the selector names (already fetched from the descriptor table by the surrounding logic), and a flag that tells whether the processor runs in long mode. The checker captures the request and tests it one rule per clock cycle in a fixed order. It stops at the first rule that fails. It then presents a one-cycle result strobe that carries either success or a single fault code.

On success the selector is written into the task register. During the same result cycle the block raises a request to write the descriptor back with its busy flag set. The memory write itself is left to the surrounding logic. On a fault the task register keeps its old value, and the index part of the offending selector is reported next to the fault code so that the fault handler can use it.

Top module: `tr_load_checker`

## Requirements
- R1: After reset `resultValid` and `setBusy` are 0, `faultCode` is 0 and `trSelector` is 0.
- R2: The selector carries the table index in bits 15:3, the table-select bit in bit 2 and the requestor privilege in bits 1:0. A table-select bit of 1 gives faultCode 1 (general protection).
- R3: Type nibble values 4'b0001, 4'b0011, 4'b1001 and 4'b1011 are the task-state types. Any other value gives faultCode 1.
- R4: When `longMode` is 1, a type with bit 3 equal to 0 (16-bit task state) gives faultCode 1. Only 4'b1001 and 4'b1011 pass the type test in long mode.
- R5: Type bit 1 is the busy flag. A descriptor with the flag set (4'b0011 or 4'b1011) gives faultCode 1.
- R6: A limit below 20'h67 gives faultCode 2 (invalid task state). A limit of exactly 20'h67 is accepted.
- R7: The tests run in the order table-select, type, busy, limit. Only the first failing test is reported.
- R8: On success `faultCode` is 0, `trSelector` equals the whole request selector during the result cycle, and `setBusy` is 1 in that cycle only.
- R9: On a fault `trSelector` keeps its previous value, `setBusy` is 0, and `faultIndex` equals selector bits 15:3. On success `faultIndex` is 0.
- R10: `resultValid` is high for exactly one cycle per accepted request. A `reqValid` that arrives while a request is being checked is ignored.
- R11: Count from the clock edge that samples `reqValid`. The result is presented after 1 further edge for a table-select fault, 2 for a type fault, 3 for a busy fault and 4 for a limit fault or a success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request, sampled only when the checker is idle |
| selector | input | 16 | Selector to load |
| descType | input | 4 | Type nibble of the fetched descriptor |
| descLimit | input | 20 | Limit of the fetched descriptor |
| longMode | input | 1 | Long mode is active |
| resultValid | output | 1 | One-cycle result strobe |
| faultCode | output | 2 | 0 none, 1 general protection, 2 invalid task state |
| faultIndex | output | 13 | Selector index of the faulting request, 0 otherwise |
| trSelector | output | 16 | Current task register selector |
| setBusy | output | 1 | Request to mark the descriptor busy |

## Verification
Each result is due a fixed number of edges after the edge that samples the request. The count is 1 for a table-select fault, 2 for a type fault, 3 for a busy fault and 4 for a limit fault or a success. The driver works out both the expected code and this due cycle when it issues a request. The monitor compares them at the falling edge after the result strobe rises. A strobe that arrives earlier or later is reported as a latency failure, and a strobe with nothing pending is reported as an unexpected result. Requests sent in while a check is running must produce no strobe of their own, and a count of results at the end confirms this.

// File: rtl/tr_load_pkg.sv
package tr_load_pkg;

  localparam int SEL_W    = 16;
  localparam int TI_BIT   = 2;
  localparam int IDX_LSB  = 3;
  localparam int IDX_W    = SEL_W - IDX_LSB;
  localparam int TYPE_W   = 4;
  localparam int BUSY_POS = 1;
  localparam int WIDE_POS = 3;

  typedef enum logic [1:0] {
    FAULT_NONE = 2'd0,
    FAULT_GP   = 2'd1,
    FAULT_TS   = 2'd2
  } faultE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK_TI,
    ST_CHK_TYPE,
    ST_CHK_BUSY,
    ST_CHK_LIMIT,
    ST_DONE
  } stateE;

  typedef struct packed {
    logic capture;
    logic commit;
    logic showIndex;
  } ctrlS;

  typedef struct packed {
    logic tiBad;
    logic typeBad;
    logic busyBad;
    logic limitBad;
  } flagsS;

endpackage

// File: rtl/trl_datapath.sv
module trl_datapath
  import tr_load_pkg::*;
#(
  parameter int LIMIT_W   = 20,
  parameter int MIN_LIMIT = 'h67
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlS               ctrl,
  input  logic [SEL_W-1:0]   selector,
  input  logic [TYPE_W-1:0]  descType,
  input  logic [LIMIT_W-1:0] descLimit,
  input  logic               longMode,
  output flagsS              flags,
  output logic [IDX_W-1:0]   faultIndex,
  output logic [SEL_W-1:0]   trSelector
);

  localparam logic [LIMIT_W-1:0] MinLimitL = LIMIT_W'(MIN_LIMIT);

  logic [SEL_W-1:0]   selReg;
  logic [TYPE_W-1:0]  typeReg;
  logic [LIMIT_W-1:0] limitReg;
  logic               longReg;
  logic [SEL_W-1:0]   trReg;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      typeReg  <= '0;
      limitReg <= '0;
      longReg  <= 1'b0;
    end else if (ctrl.capture) begin
      selReg   <= selector;
      typeReg  <= descType;
      limitReg <= descLimit;
      longReg  <= longMode;
    end
  end

  // task register
  always_ff @(posedge clk) begin
    if (!rstN) trReg <= '0;
    else if (ctrl.commit) trReg <= selReg;
  end

  logic typeIsTss;
  logic typeWideOk;

  always_comb begin
    // task-state types: bit0 set, bit2 clear; bit3 marks the wide form
    typeIsTss  = typeReg[0] && !typeReg[2];
    typeWideOk = !longReg || typeReg[WIDE_POS];
    flags.tiBad    = selReg[TI_BIT];
    flags.typeBad  = !(typeIsTss && typeWideOk);
    flags.busyBad  = typeReg[BUSY_POS];
    flags.limitBad = (limitReg < MinLimitL);
  end

  assign faultIndex = ctrl.showIndex ? selReg[SEL_W-1:IDX_LSB] : '0;
  assign trSelector = trReg;

endmodule

// File: rtl/trl_control.sv
module trl_control
  import tr_load_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  flagsS      flags,
  output ctrlS       ctrl,
  output logic       resultValid,
  output logic [1:0] faultCode,
  output logic       setBusy
);

  stateE state, nextState;
  faultE faultReg, nextFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultReg <= FAULT_NONE;
    end else begin
      state    <= nextState;
      faultReg <= nextFault;
    end
  end

  always_comb begin
    ctrl        = '0;
    nextState   = state;
    nextFault   = faultReg;
    resultValid = 1'b0;
    faultCode   = FAULT_NONE;
    setBusy     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.capture = 1'b1;
          nextFault    = FAULT_NONE;
          nextState    = ST_CHK_TI;
        end
      end
      ST_CHK_TI: begin
        if (flags.tiBad) begin
          nextFault = FAULT_GP;
          nextState = ST_DONE;
        end else begin
          nextState = ST_CHK_TYPE;
        end
      end
      ST_CHK_TYPE: begin
        if (flags.typeBad) begin
          nextFault = FAULT_GP;
          nextState = ST_DONE;
        end else begin
          nextState = ST_CHK_BUSY;
        end
      end
      ST_CHK_BUSY: begin
        if (flags.busyBad) begin
          nextFault = FAULT_GP;
          nextState = ST_DONE;
        end else begin
          nextState = ST_CHK_LIMIT;
        end
      end
      ST_CHK_LIMIT: begin
        if (flags.limitBad) begin
          nextFault = FAULT_TS;
        end else begin
          ctrl.commit = 1'b1;
        end
        nextState = ST_DONE;
      end
      ST_DONE: begin
        resultValid    = 1'b1;
        faultCode      = faultReg;
        setBusy        = (faultReg == FAULT_NONE);
        ctrl.showIndex = (faultReg != FAULT_NONE);
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tr_load_checker.sv
module tr_load_checker
  import tr_load_pkg::*;
#(
  parameter int LIMIT_W   = 20,
  parameter int MIN_LIMIT = 'h67
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [15:0]        selector,
  input  logic [3:0]         descType,
  input  logic [LIMIT_W-1:0] descLimit,
  input  logic               longMode,
  output logic               resultValid,
  output logic [1:0]         faultCode,
  output logic [12:0]        faultIndex,
  output logic [15:0]        trSelector,
  output logic               setBusy
);

  ctrlS  ctrl;
  flagsS flags;

  trl_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .flags      (flags),
    .ctrl       (ctrl),
    .resultValid(resultValid),
    .faultCode  (faultCode),
    .setBusy    (setBusy)
  );

  trl_datapath #(
    .LIMIT_W  (LIMIT_W),
    .MIN_LIMIT(MIN_LIMIT)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .selector  (selector),
    .descType  (descType),
    .descLimit (descLimit),
    .longMode  (longMode),
    .flags     (flags),
    .faultIndex(faultIndex),
    .trSelector(trSelector)
  );

endmodule

// File: rtl/tr_load_checker_sva.sv
module tr_load_checker_sva (
  input logic        clk,
  input logic        rstN,
  input logic        resultValid,
  input logic [1:0]  faultCode,
  input logic [12:0] faultIndex,
  input logic [15:0] trSelector,
  input logic        setBusy
);

  // R10: strobe lasts one cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R9: a fault leaves the task register as it was
  a_r9_tr_kept_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && faultCode != 2'd0) |-> $stable(trSelector));

  // R9: index only reported with a fault
  a_r9_index_zero_on_ok: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode == 2'd0) |-> (faultIndex == 13'd0));

  // R8: busy write-back only with a successful result
  a_r8_busy_with_success: assert property (@(posedge clk) disable iff (!rstN)
    setBusy |-> (resultValid && faultCode == 2'd0));

  // R8: every success asks for the busy write-back
  a_r8_success_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && faultCode == 2'd0) |-> setBusy);

  // R2: a loaded selector never points at the local table
  a_r2_loaded_ti_clear: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && faultCode == 2'd0) |-> !trSelector[2]);

  // R1: no code outside a result strobe, and code 3 never appears
  a_r1_code_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> (faultCode == 2'd0 && !setBusy));

  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    faultCode != 2'd3);

endmodule

bind tr_load_checker tr_load_checker_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .resultValid(resultValid),
  .faultCode  (faultCode),
  .faultIndex (faultIndex),
  .trSelector (trSelector),
  .setBusy    (setBusy)
);

// File: tb/tr_load_checker_bench.sv
module tr_load_checker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] selector = '0;
  logic [3:0]  descType = '0;
  logic [19:0] descLimit = '0;
  logic        longMode = 1'b0;
  logic        resultValid;
  logic [1:0]  faultCode;
  logic [12:0] faultIndex;
  logic [15:0] trSelector;
  logic        setBusy;

  always #5 clk = ~clk;

  tr_load_checker u_tr_load_checker (.*);

  typedef struct {
    logic [1:0]  code;
    logic [12:0] index;
    logic [15:0] tr;
    int          due;
    string       tag;
  } itemT;

  itemT queueQ[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   results = 0;
  int   expResults = 0;
  bit   finished = 0;
  logic [15:0] expTr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: computes the expected outcome from the requirements and queues it
  task automatic issue(input logic [15:0] sel, input logic [3:0] typ,
                       input logic [19:0] lim, input logic lm, input string tag);
    itemT it;
    int   lat;
    bit   legal;
    legal = typ[0] && !typ[2] && (!lm || typ[3]);
    if (sel[2]) begin it.code = 2'd1; lat = 1; end
    else if (!legal) begin it.code = 2'd1; lat = 2; end
    else if (typ[1]) begin it.code = 2'd1; lat = 3; end
    else if (lim < 20'h67) begin it.code = 2'd2; lat = 4; end
    else begin it.code = 2'd0; lat = 4; end
    if (it.code == 2'd0) begin
      expTr = sel;
      it.index = '0;
    end else begin
      it.index = sel[15:3];
    end
    it.tr  = expTr;
    it.due = cyc + 1 + lat;
    it.tag = tag;
    queueQ.push_back(it);
    expResults++;
    reqValid  = 1'b1;
    selector  = sel;
    descType  = typ;
    descLimit = lim;
    longMode  = lm;
    @(negedge clk);
    reqValid  = 1'b0;
  endtask

  task automatic waitDone();
    while (queueQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [15:0] sel, input logic [3:0] typ,
                     input logic [19:0] lim, input logic lm, input string tag);
    @(negedge clk);
    issue(sel, typ, lim, lm, tag);
    waitDone();
  endtask

  // monitor: pops and compares at each result strobe
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      results++;
      if (queueQ.size() == 0) begin
        check(0, "R10", "unexpected result", 1, 0);
      end else begin
        itemT it;
        it = queueQ.pop_front();
        check(faultCode == it.code, it.tag, "faultCode", faultCode, it.code);
        check(faultIndex == it.index, "R9", "faultIndex", faultIndex, it.index);
        check(trSelector == it.tr, it.code == 0 ? "R8" : "R9", "trSelector",
              trSelector, it.tr);
        check(setBusy == (it.code == 2'd0), "R8", "setBusy", setBusy,
              it.code == 2'd0);
        check(cyc == it.due, "R11", "latency cycle", cyc, it.due);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(resultValid == 0 && setBusy == 0, "R1", "strobes", {resultValid, setBusy}, 0);
    check(faultCode == 0, "R1", "faultCode", faultCode, 0);
    check(trSelector == 0, "R1", "trSelector", trSelector, 0);
    rstN = 1'b1;
    @(negedge clk);

    run(16'h0018, 4'b1001, 20'h67, 1'b1, "R6");   // boundary limit accepted, wide type
    run(16'h002C, 4'b1001, 20'hFFFF, 1'b1, "R2"); // local table bit
    run(16'h0030, 4'b0010, 20'hFFFF, 1'b0, "R3"); // not a task-state type
    run(16'h0040, 4'b0101, 20'hFFFF, 1'b0, "R3"); // bit2 set
    run(16'h0049, 4'b0001, 20'h100, 1'b0, "R3");  // narrow type legal outside long mode
    run(16'h0050, 4'b0001, 20'h100, 1'b1, "R4");  // narrow type in long mode
    run(16'h0058, 4'b1011, 20'h100, 1'b1, "R5");  // already busy
    run(16'h0060, 4'b0011, 20'h100, 1'b0, "R5");  // narrow busy
    run(16'h0068, 4'b1001, 20'h66, 1'b0, "R6");   // limit one below minimum
    run(16'h007F, 4'b0110, 20'h0, 1'b1, "R7");    // all checks fail: first wins
    run(16'h0080, 4'b1011, 20'h10, 1'b0, "R7");   // busy beats limit
    run(16'h0088, 4'b0001, 20'h10, 1'b1, "R7");   // type beats limit
    run(16'h0093, 4'b1001, 20'hFFFFF, 1'b0, "R8");

    // R10: request during evaluation is ignored
    @(negedge clk);
    issue(16'h00A0, 4'b1001, 20'h200, 1'b1, "R10");
    reqValid = 1'b1;
    selector = 16'h00AC;
    descType = 4'b0000;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    repeat (6) @(negedge clk);
    check(results == expResults, "R10", "result count", results, expResults);
    check(trSelector == 16'h00A0, "R10", "trSelector after stray", trSelector, 16'h00A0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule